// File: doc/BRIEF.md
# Speculation-aware translation buffer with store snooping

This block is a small fully associative translation buffer that sits beside a hardware page walker. The walker may install a translation early, before any access in program order has actually missed on that page. Such an entry is held as speculative until a retiring access uses it. While it is speculative, the block compares every store address against the location of the page-table entry it was built from. If a store lands on that 8-byte location, the entry is stale. The block drops it and pulses a misspeculation flag so the pipeline can replay.

Once a retiring access has used an entry, the entry is architectural. Stores to its page-table entry are then left to ordinary software invalidation. Only valid translations are held, so a missing translation is never remembered, and every missed lookup asks for a fresh walk. Software-driven maintenance can remove one page or clear the whole buffer.

Lookups resolve in the same cycle. Every state change (fills, kills, invalidates, use marking and replacement order) takes effect at the next rising clock edge. All of these changes are judged against the contents held at the start of the cycle.

Top module: `snoop_tlb`

## Requirements
- R1: With `lk_valid_i` high, `lk_hit_o` is 1 in the same cycle when a valid entry holds `lk_vpn_i`, and `lk_ppn_o`/`lk_perm_o` then show that entry's fields. On a miss, or with no lookup, both fields read 0.
- R2: `lk_walk_o` equals `lk_valid_i` and not `lk_hit_o`. A page that missed before raises a walk request again on every later miss, because no negative entry is ever held.
- R3: An accepted fill is visible to lookups from the cycle after it is presented. A fill for a page already held overwrites that entry, so at most one entry ever matches a page.
- R4: The fill slot is chosen from the start-of-cycle contents, in this order: first the entry already holding the page; otherwise the lowest-index invalid entry; otherwise the victim of a binary-tree pseudo-LRU. The tree has node 0 as root and nodes 2k+1 and 2k+2 as the children of node k. The way index is read MSB first, and a node bit of 0 points at the lower half. A touch sets each node on the path to point away from the touched way. A lookup hit touches its entry, and an accepted fill touches its slot afterwards. Reset clears all tree bits.
- R5: `fill_spec_i`=1 installs the entry as speculative. `fill_spec_i`=0 installs it as architectural, and a store to its page-table entry then neither removes it nor raises `misspec_o`.
- R6: Suppose a snooped store's address equals, in bits [31:3], the page-table address of a valid speculative entry. That entry is removed, and `misspec_o` is 1 for exactly the following cycle. Without such a match, and without the R8 clash, `misspec_o` is 0.
- R7: `use_valid_i` with `use_vpn_i` matching a valid entry makes that entry architectural. Later stores to its page-table entry leave it in place and raise no `misspec_o`.
- R8: Suppose a snoop and a fill arrive in the same cycle and their addresses agree in bits [31:3]. The fill is discarded, and `misspec_o` is 1 in the next cycle.
- R9: `inv_page_i` removes the entry holding `inv_vpn_i` and leaves all others. A fill for the same page in that cycle is discarded.
- R10: `flush_i` clears every entry, and a fill in that cycle is discarded.
- R11: After reset no entry is valid, `misspec_o` is 0 and every lookup misses.
- R12: Snoop matching uses the speculative flag as held at the start of the cycle. A retire-use in the same cycle as a matching store does not save the entry, and a lookup in the same cycle as a fill sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | 20 | Lookup virtual page |
| lk_hit_o | output | 1 | Lookup hit, same cycle |
| lk_walk_o | output | 1 | Lookup missed, page walk wanted |
| lk_ppn_o | output | 20 | Physical page of the hit entry |
| lk_perm_o | output | 4 | Permission bits of the hit entry |
| fill_valid_i | input | 1 | Fill from the walker |
| fill_vpn_i | input | 20 | Fill virtual page |
| fill_ppn_i | input | 20 | Fill physical page |
| fill_perm_i | input | 4 | Fill permission bits |
| fill_pte_i | input | 32 | Physical address of the page-table entry behind the fill |
| fill_spec_i | input | 1 | Fill is speculative |
| use_valid_i | input | 1 | A retiring access used a translation |
| use_vpn_i | input | 20 | Page used by the retiring access |
| snoop_valid_i | input | 1 | A store is observed |
| snoop_addr_i | input | 32 | Byte address of the observed store |
| inv_page_i | input | 1 | Invalidate one page |
| inv_vpn_i | input | 20 | Page to invalidate |
| flush_i | input | 1 | Invalidate all entries |
| misspec_o | output | 1 | A speculative translation went stale, one-cycle pulse |

## Verification
The assertions take for granted that every qualifier is 0 or 1 after reset. The data buses are only acted on while their qualifier is high. The single-match property relies on the walker sending each fill with its own page number, which lets the block steer a repeated page onto the slot that already holds it. The stimulus draws pages from a pool of 24 so that hits, repeated fills and full-table eviction all occur. Each page is given its own 8-byte page-table slot, and snoops carry random low address bits so that the granule comparison is exercised. Invalidates and flushes are kept rare so the table spends most of its time full.

// File: rtl/snoop_tlb_pkg.sv
`timescale 1ns/1ps
package snoop_tlb_pkg;
  localparam int unsigned VPN_W  = 20;
  localparam int unsigned PPN_W  = 20;
  localparam int unsigned PERM_W = 4;
  localparam int unsigned PA_W   = 32;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] perm;
    logic [PA_W-1:0]   pte;
    logic              spec;
  } tlb_ent_t;
endpackage

// File: rtl/tlb_slot.sv
`timescale 1ns/1ps
module tlb_slot import snoop_tlb_pkg::*; #(
  parameter int unsigned GRAN_LSB = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic              use_valid_i,
  input  logic [VPN_W-1:0]  use_vpn_i,
  input  logic              snoop_valid_i,
  input  logic [PA_W-1:0]   snoop_addr_i,
  input  logic              inv_page_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic              flush_i,
  input  logic              wr_i,
  input  tlb_ent_t          wr_ent_i,
  output logic              lk_match_o,
  output logic              fill_match_o,
  output logic              kill_o,
  output logic              valid_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic [PERM_W-1:0] perm_o
);
  localparam logic [PA_W-1:0] GRAN_MASK = {PA_W{1'b1}} << GRAN_LSB;

  logic     valid_q;
  tlb_ent_t ent_q;
  logic     use_hit, inv_hit;

  assign lk_match_o   = valid_q && (ent_q.vpn == lk_vpn_i);
  assign fill_match_o = valid_q && (ent_q.vpn == fill_vpn_i);
  assign use_hit      = use_valid_i && valid_q && (ent_q.vpn == use_vpn_i);
  assign inv_hit      = inv_page_i && valid_q && (ent_q.vpn == inv_vpn_i);
  // stale speculative entry: store hits its 8-byte table slot
  assign kill_o       = snoop_valid_i && valid_q && ent_q.spec &&
                        (((snoop_addr_i ^ ent_q.pte) & GRAN_MASK) == '0);
  assign valid_o      = valid_q;
  assign ppn_o        = ent_q.ppn;
  assign perm_o       = ent_q.perm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      ent_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (wr_i) begin
      valid_q <= 1'b1;
      ent_q   <= wr_ent_i;
    end else begin
      if (kill_o || inv_hit) valid_q <= 1'b0;
      if (use_hit) ent_q.spec <= 1'b0;
    end
  end

  AST_SPEC_KILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_o && !wr_i) |=> !valid_q); // R6
  AST_USE_ARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (use_hit && !wr_i && !flush_i) |=> !ent_q.spec); // R7
  AST_INV_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inv_hit && !wr_i) |=> !valid_q); // R9
  AST_FLUSH_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !valid_q); // R10
  AST_FILL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !flush_i) |=> (valid_q && ent_q == $past(wr_ent_i))); // R3
endmodule

// File: rtl/tlb_plru.sv
`timescale 1ns/1ps
module tlb_plru #(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_a_i,
  input  logic [IDX_W-1:0] touch_a_idx_i,
  input  logic             touch_b_i,
  input  logic [IDX_W-1:0] touch_b_idx_i,
  output logic [IDX_W-1:0] victim_o
);
  // node k has children 2k+1, 2k+2; slot N_ENT-1 is spare
  logic [N_ENT-1:0] bits_q, bits_d;

  function automatic logic [N_ENT-1:0] touch(input logic [N_ENT-1:0] b,
                                             input logic [IDX_W-1:0] way);
    logic [N_ENT-1:0] r;
    logic [IDX_W-1:0] node;
    logic             dir;
    r    = b;
    node = '0;
    for (int lv = 0; lv < int'(IDX_W); lv++) begin
      dir     = way[IDX_W-1-lv];
      r[node] = ~dir;
      node    = IDX_W'(32'(node) * 2 + 32'(dir) + 1);
    end
    return r;
  endfunction

  always_comb begin
    bits_d = bits_q;
    if (touch_a_i) bits_d = touch(bits_d, touch_a_idx_i);
    if (touch_b_i) bits_d = touch(bits_d, touch_b_idx_i);
  end

  always_comb begin
    logic [IDX_W-1:0] node;
    logic             dir;
    victim_o = '0;
    node     = '0;
    for (int lv = 0; lv < int'(IDX_W); lv++) begin
      dir                  = bits_q[node];
      victim_o[IDX_W-1-lv] = dir;
      node                 = IDX_W'(32'(node) * 2 + 32'(dir) + 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bits_q <= '0;
    else         bits_q <= bits_d;
  end

  AST_VICTIM_NOT_MRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_b_i |=> (victim_o != $past(touch_b_idx_i))); // R4
endmodule

// File: rtl/tlb_repl.sv
`timescale 1ns/1ps
module tlb_repl #(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] valid_i,
  input  logic [N_ENT-1:0] same_i,
  input  logic [IDX_W-1:0] plru_i,
  output logic [IDX_W-1:0] tgt_o
);
  logic [IDX_W-1:0] same_idx, free_idx;
  logic             has_same, has_free;

  always_comb begin
    same_idx = '0;
    free_idx = '0;
    has_same = 1'b0;
    has_free = 1'b0;
    for (int i = int'(N_ENT) - 1; i >= 0; i--) begin
      if (same_i[i]) begin
        same_idx = IDX_W'(i);
        has_same = 1'b1;
      end
      if (!valid_i[i]) begin
        free_idx = IDX_W'(i);
        has_free = 1'b1;
      end
    end
    if (has_same)      tgt_o = same_idx;
    else if (has_free) tgt_o = free_idx;
    else               tgt_o = plru_i;
  end

  AST_REPL_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~valid_i != '0) && (same_i == '0)) |-> !valid_i[tgt_o]); // R4
  AST_REPL_SAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_i != '0) |-> same_i[tgt_o]); // R3
endmodule

// File: rtl/snoop_tlb.sv
`timescale 1ns/1ps
module snoop_tlb import snoop_tlb_pkg::*; #(
  parameter int unsigned N_ENT    = 16,
  parameter int unsigned GRAN_LSB = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              lk_hit_o,
  output logic              lk_walk_o,
  output logic [PPN_W-1:0]  lk_ppn_o,
  output logic [PERM_W-1:0] lk_perm_o,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PPN_W-1:0]  fill_ppn_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic [PA_W-1:0]   fill_pte_i,
  input  logic              fill_spec_i,
  input  logic              use_valid_i,
  input  logic [VPN_W-1:0]  use_vpn_i,
  input  logic              snoop_valid_i,
  input  logic [PA_W-1:0]   snoop_addr_i,
  input  logic              inv_page_i,
  input  logic [VPN_W-1:0]  inv_vpn_i,
  input  logic              flush_i,
  output logic              misspec_o
);
  localparam int unsigned    IDX_W     = $clog2(N_ENT);
  localparam logic [PA_W-1:0] GRAN_MASK = {PA_W{1'b1}} << GRAN_LSB;

  logic [N_ENT-1:0]  hit_vec, same_vec, kill_vec, valid_vec, wr_vec;
  logic [PPN_W-1:0]  ppn_arr  [N_ENT];
  logic [PERM_W-1:0] perm_arr [N_ENT];
  logic [IDX_W-1:0]  hit_idx, tgt_idx, plru_victim;
  logic              any_hit, fill_clash, fill_ok, misspec_q;
  tlb_ent_t          wr_ent;

  assign wr_ent = '{vpn: fill_vpn_i, ppn: fill_ppn_i, perm: fill_perm_i,
                    pte: fill_pte_i, spec: fill_spec_i};

  for (genvar g = 0; g < int'(N_ENT); g++) begin : g_slot
    tlb_slot #(.GRAN_LSB(GRAN_LSB)) u_slot (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .lk_vpn_i     (lk_vpn_i),
      .fill_vpn_i   (fill_vpn_i),
      .use_valid_i  (use_valid_i),
      .use_vpn_i    (use_vpn_i),
      .snoop_valid_i(snoop_valid_i),
      .snoop_addr_i (snoop_addr_i),
      .inv_page_i   (inv_page_i),
      .inv_vpn_i    (inv_vpn_i),
      .flush_i      (flush_i),
      .wr_i         (wr_vec[g]),
      .wr_ent_i     (wr_ent),
      .lk_match_o   (hit_vec[g]),
      .fill_match_o (same_vec[g]),
      .kill_o       (kill_vec[g]),
      .valid_o      (valid_vec[g]),
      .ppn_o        (ppn_arr[g]),
      .perm_o       (perm_arr[g])
    );
    assign wr_vec[g] = fill_ok && (tgt_idx == IDX_W'(g));
  end

  always_comb begin
    hit_idx   = '0;
    lk_ppn_o  = '0;
    lk_perm_o = '0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      if (hit_vec[i]) begin
        hit_idx   = hit_idx | IDX_W'(i);
        lk_ppn_o  = lk_ppn_o | ppn_arr[i];
        lk_perm_o = lk_perm_o | perm_arr[i];
      end
    end
    if (!lk_valid_i) begin
      lk_ppn_o  = '0;
      lk_perm_o = '0;
    end
  end

  assign any_hit   = |hit_vec;
  assign lk_hit_o  = lk_valid_i && any_hit;
  assign lk_walk_o = lk_valid_i && !any_hit;

  // store to the very slot being installed: walker read a value now stale
  assign fill_clash = snoop_valid_i && fill_valid_i &&
                      (((snoop_addr_i ^ fill_pte_i) & GRAN_MASK) == '0);
  assign fill_ok    = fill_valid_i && !flush_i && !fill_clash &&
                      !(inv_page_i && (inv_vpn_i == fill_vpn_i));

  tlb_repl #(.N_ENT(N_ENT)) u_repl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_vec),
    .same_i (same_vec),
    .plru_i (plru_victim),
    .tgt_o  (tgt_idx)
  );

  tlb_plru #(.N_ENT(N_ENT)) u_plru (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .touch_a_i    (lk_hit_o),
    .touch_a_idx_i(hit_idx),
    .touch_b_i    (fill_ok),
    .touch_b_idx_i(tgt_idx),
    .victim_o     (plru_victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) misspec_q <= 1'b0;
    else         misspec_q <= (|kill_vec) || fill_clash;
  end
  assign misspec_o = misspec_q;

  AST_ONE_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec)); // R3
  AST_CLASH_MISSPEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_clash |=> misspec_o); // R8
  AST_QUIET_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snoop_valid_i |=> !misspec_o); // R6
  AST_CLASH_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_clash |-> (wr_vec == '0)); // R8
endmodule

// File: tb/snoop_tlb_tb.sv
`timescale 1ns/1ps
module snoop_tlb_tb;
  localparam int N = 16;
  localparam int L = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lk_valid_i, fill_valid_i, fill_spec_i, use_valid_i;
  logic        snoop_valid_i, inv_page_i, flush_i;
  logic [19:0] lk_vpn_i, fill_vpn_i, fill_ppn_i, use_vpn_i, inv_vpn_i;
  logic [3:0]  fill_perm_i;
  logic [31:0] fill_pte_i, snoop_addr_i;
  logic        lk_hit_o, lk_walk_o, misspec_o;
  logic [19:0] lk_ppn_o;
  logic [3:0]  lk_perm_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          m_v [N];
  bit          m_s [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_ppn [N];
  logic [3:0]  m_perm [N];
  logic [31:0] m_pte [N];
  bit          t [N];
  bit          m_mis;

  always #2 clk_i = ~clk_i;

  snoop_tlb u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_vpn_i(lk_vpn_i), .lk_hit_o(lk_hit_o),
    .lk_walk_o(lk_walk_o), .lk_ppn_o(lk_ppn_o), .lk_perm_o(lk_perm_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_perm_i(fill_perm_i), .fill_pte_i(fill_pte_i), .fill_spec_i(fill_spec_i),
    .use_valid_i(use_valid_i), .use_vpn_i(use_vpn_i),
    .snoop_valid_i(snoop_valid_i), .snoop_addr_i(snoop_addr_i),
    .inv_page_i(inv_page_i), .inv_vpn_i(inv_vpn_i), .flush_i(flush_i),
    .misspec_o(misspec_o)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_in();
    lk_valid_i = 0; lk_vpn_i = 0; fill_valid_i = 0; fill_vpn_i = 0;
    fill_ppn_i = 0; fill_perm_i = 0; fill_pte_i = 0; fill_spec_i = 0;
    use_valid_i = 0; use_vpn_i = 0; snoop_valid_i = 0; snoop_addr_i = 0;
    inv_page_i = 0; inv_vpn_i = 0; flush_i = 0;
  endtask

  function automatic int m_victim();
    int node = 0;
    int v = 0;
    for (int lv = 0; lv < L; lv++) begin
      int b = int'(t[node]);
      v = v * 2 + b;
      node = 2 * node + 1 + b;
    end
    return v;
  endfunction

  task automatic m_touch(input int w);
    int node = 0;
    for (int lv = 0; lv < L; lv++) begin
      int b = (w >> (L - 1 - lv)) & 1;
      t[node] = (b == 0);
      node = 2 * node + 1 + b;
    end
  endtask

  function automatic int m_find(input logic [19:0] vpn);
    for (int i = 0; i < N; i++) if (m_v[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic model_tick();
    int hit, same, free, tgt;
    bit clash, ok, mis;
    hit  = lk_valid_i ? m_find(lk_vpn_i) : -1;
    same = m_find(fill_vpn_i);
    free = -1;
    for (int i = N - 1; i >= 0; i--) if (!m_v[i]) free = i;
    tgt = (same >= 0) ? same : (free >= 0) ? free : m_victim();
    clash = snoop_valid_i && fill_valid_i && ((snoop_addr_i >> 3) == (fill_pte_i >> 3));
    mis = clash;
    for (int i = 0; i < N; i++)
      if (snoop_valid_i && m_v[i] && m_s[i] && ((m_pte[i] >> 3) == (snoop_addr_i >> 3)))
        mis = 1;
    ok = fill_valid_i && !flush_i && !clash && !(inv_page_i && inv_vpn_i == fill_vpn_i);
    if (flush_i) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        bit pv = m_v[i];
        if (pv && snoop_valid_i && m_s[i] && ((m_pte[i] >> 3) == (snoop_addr_i >> 3))) m_v[i] = 0;
        if (pv && inv_page_i && m_vpn[i] == inv_vpn_i) m_v[i] = 0;
        if (pv && use_valid_i && m_vpn[i] == use_vpn_i) m_s[i] = 0;
      end
    end
    if (hit >= 0) m_touch(hit);
    if (ok) begin
      m_touch(tgt);
      m_v[tgt] = 1; m_s[tgt] = fill_spec_i; m_vpn[tgt] = fill_vpn_i;
      m_ppn[tgt] = fill_ppn_i; m_perm[tgt] = fill_perm_i; m_pte[tgt] = fill_pte_i;
    end
    m_mis = mis;
  endtask

  // called just after a falling edge with inputs set
  task automatic step();
    int h;
    #0.5;
    h = lk_valid_i ? m_find(lk_vpn_i) : -1;
    chk(lk_hit_o, h >= 0, "R1 hit");
    chk(lk_walk_o, lk_valid_i && h < 0, "R2 walk");
    chk(lk_ppn_o, h >= 0 ? m_ppn[h] : 20'h0, "R1 ppn");
    chk(lk_perm_o, h >= 0 ? m_perm[h] : 4'h0, "R1 perm");
    chk(misspec_o, m_mis, "R6 misspec");
    @(posedge clk_i);
    model_tick();
    @(negedge clk_i);
    clear_in();
  endtask

  task automatic probe(input logic [19:0] vpn, input bit exp_hit,
                       input logic [19:0] exp_ppn, input string tag);
    lk_valid_i = 1; lk_vpn_i = vpn;
    #0.2;
    chk(lk_hit_o, exp_hit, tag);
    chk(lk_walk_o, !exp_hit, "R2 walk on miss");
    if (exp_hit) chk(lk_ppn_o, exp_ppn, tag);
    step();
  endtask

  task automatic do_fill(input logic [19:0] vpn, input logic [19:0] ppn,
                         input logic [31:0] pte, input bit spec);
    fill_valid_i = 1; fill_vpn_i = vpn; fill_ppn_i = ppn;
    fill_perm_i = ppn[3:0]; fill_pte_i = pte; fill_spec_i = spec;
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [19:0] vic_vpn;
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_s[i] = 0; t[i] = 0;
      m_vpn[i] = 0; m_ppn[i] = 0; m_perm[i] = 0; m_pte[i] = 0;
    end
    m_mis = 0;
    clear_in();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk(misspec_o, 0, "R11 misspec");
    probe(20'h5, 0, 0, "R11 empty");

    do_fill(20'h5, 20'hAA, 32'h1000, 1);
    lk_valid_i = 1; lk_vpn_i = 20'h5;
    #0.2 chk(lk_hit_o, 0, "R12 lookup sees old contents");
    step();
    probe(20'h5, 1, 20'hAA, "R3 fill visible");
    probe(20'h9, 0, 0, "R2 miss");
    probe(20'h9, 0, 0, "R2 repeat miss");

    snoop_valid_i = 1; snoop_addr_i = 32'h1005;
    step();
    chk(misspec_o, 1, "R6 pulse");
    probe(20'h5, 0, 0, "R6 entry removed");
    chk(misspec_o, 0, "R6 single cycle");

    do_fill(20'h6, 20'h66, 32'h2000, 1); step();
    use_valid_i = 1; use_vpn_i = 20'h6; step();
    snoop_valid_i = 1; snoop_addr_i = 32'h2000; step();
    chk(misspec_o, 0, "R7 no misspec");
    probe(20'h6, 1, 20'h66, "R7 kept");

    do_fill(20'h7, 20'h77, 32'h3000, 0); step();
    snoop_valid_i = 1; snoop_addr_i = 32'h3004; step();
    chk(misspec_o, 0, "R5 arch fill");
    probe(20'h7, 1, 20'h77, "R5 kept");

    do_fill(20'h8, 20'h88, 32'h4000, 1);
    snoop_valid_i = 1; snoop_addr_i = 32'h4007; step();
    chk(misspec_o, 1, "R8 clash");
    probe(20'h8, 0, 0, "R8 fill dropped");

    inv_page_i = 1; inv_vpn_i = 20'h6; step();
    probe(20'h6, 0, 0, "R9 removed");
    probe(20'h7, 1, 20'h77, "R9 other kept");
    do_fill(20'h9, 20'h99, 32'h5000, 1);
    inv_page_i = 1; inv_vpn_i = 20'h9; step();
    probe(20'h9, 0, 0, "R9 fill dropped");

    do_fill(20'hA, 20'hA0, 32'h6000, 1);
    flush_i = 1; step();
    probe(20'h7, 0, 0, "R10 cleared");
    probe(20'hA, 0, 0, "R10 fill dropped");

    for (int k = 0; k < N; k++) begin
      do_fill(20'h100 + 20'(k), 20'h500 + 20'(k), 32'h8000 + 32'(k) * 8, 0);
      step();
    end
    probe(20'h100, 1, 20'h500, "R4 slot fill");
    vic_vpn = m_vpn[m_victim()];
    do_fill(20'h200, 20'h600, 32'h9000, 0); step();
    probe(vic_vpn, 0, 0, "R4 victim evicted");
    probe(20'h100, 1, 20'h500, "R4 recent kept");
    probe(20'h200, 1, 20'h600, "R4 new present");

    do_fill(20'h300, 20'h700, 32'h7000, 1); step();
    use_valid_i = 1; use_vpn_i = 20'h300;
    snoop_valid_i = 1; snoop_addr_i = 32'h7000; step();
    chk(misspec_o, 1, "R12 use same cycle");
    probe(20'h300, 0, 0, "R12 killed");

    for (int c = 0; c < 4000; c++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 70) begin lk_valid_i = 1; lk_vpn_i = 20'($urandom_range(0, 23)); end
      if ($urandom_range(0, 99) < 30) begin
        int v = $urandom_range(0, 23);
        do_fill(20'(v), 20'($urandom), 32'h0008_0000 + 32'(v) * 8, 1'($urandom));
      end
      if ($urandom_range(0, 99) < 30) begin use_valid_i = 1; use_vpn_i = 20'($urandom_range(0, 23)); end
      if ($urandom_range(0, 99) < 15) begin
        snoop_valid_i = 1;
        snoop_addr_i = 32'h0008_0000 + 32'($urandom_range(0, 25)) * 8 + 32'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 99) < 5) begin inv_page_i = 1; inv_vpn_i = 20'($urandom_range(0, 23)); end
      if ($urandom_range(0, 999) < 8) flush_i = 1;
      step();
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule